// File: doc/BRIEF.md
# Bitmap-Level Longest Prefix Lookup Engine

This block resolves the longest matching route prefix for a destination address. Presence of a prefix of each length from 0 up to a pivot length is recorded in one on-chip bitmap per length. A signed entry array sits at the pivot length. A separate leaf table holds the routes longer than the pivot, and it is organised as fixed-size chunks that are indexed by the address bits below the pivot.

A lookup first probes the pivot bitmap. If that bit is set, the signed pivot entry gives the result. A non-negative entry is a next hop, and a negative entry names a chunk whose leaf entry supplies the next hop. If the pivot bit is clear, the engine probes shorter lengths one per cycle, from longest to shortest, and stops at the first set bit. It then reads that length's next-hop array in a separate cycle. When no bit is set at any length, it returns a default next hop and raises a miss flag.

Software maintains the table through an update port. One update inserts or deletes a single short prefix, or writes one leaf entry. Each update is one write in one cycle. The engine handles one lookup at a time, and it accepts updates only while it is idle and no lookup is being offered.

The defaults are sized for elaboration: 12-bit addresses, pivot length 8, 16-entry chunks, 8 chunks, and 8-bit next hops. An IPv4 deployment uses a 32-bit address with pivot length 24, which gives 256-entry chunks.

Top module: `lpm_engine`

## Requirements
- R1: After reset, lk_ready and upd_ready are 1 and res_valid is 0. The bitmaps are empty, so every lookup misses.
- R2: If the pivot bitmap bit at index addr[ADDR_W-1 -: PIVOT_LEN] is 1 and the pivot entry's sign bit (bit NH_W) is 0, the result is res_nh = entry[NH_W-1:0], res_len = PIVOT_LEN and res_miss = 0. res_valid rises on the 1st rising edge after the edge that accepts the lookup.
- R3: If the pivot bit is 1 and the entry's sign bit is 1, the entry equals minus a chunk number c, where 1 <= c <= NUM_CHUNKS. The result is the leaf entry at (c-1)*2^(ADDR_W-PIVOT_LEN) + the low ADDR_W-PIVOT_LEN address bits, with res_len = ADDR_W and res_miss = 0. res_valid rises on the 2nd edge after acceptance.
- R4: If the pivot bit is 0, the result comes from the longest length L < PIVOT_LEN whose bit at index addr >> (ADDR_W-L) is set. It is that length's next-hop entry at the same index, with res_len = L and res_miss = 0. res_valid rises on edge PIVOT_LEN-L+2 after acceptance.
- R5: If no bit is set at any length, the result is res_nh = DEFAULT_NH, res_len = 0 and res_miss = 1, on edge PIVOT_LEN+1 after acceptance.
- R6: Insert (upd_op = 0) with upd_len <= PIVOT_LEN sets the bit at index upd_key >> (ADDR_W-upd_len). When upd_len < PIVOT_LEN it stores upd_data[NH_W-1:0] as that length's next hop. When upd_len = PIVOT_LEN it stores all of upd_data as the signed pivot entry.
- R7: Delete (upd_op = 1) with upd_len <= PIVOT_LEN clears that bit, so later lookups fall through to shorter lengths.
- R8: Leaf write (upd_op = 2) stores upd_data[NH_W-1:0] at leaf index upd_key[LEAF_AW-1:0].
- R9: lk_ready is 1 exactly while the engine is idle. It falls on the edge after an accepted lookup and stays low until the result is produced. res_valid is a single-cycle pulse, and it occurs only while lk_ready is 1.
- R10: upd_ready is 1 only while lk_ready is 1 and lk_valid is 0. An update with upd_op = 3, or an insert or delete with upd_len > PIVOT_LEN, changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Engine idle, lookup accepted when valid |
| lk_addr | input | ADDR_W | Destination address to resolve |
| upd_valid | input | 1 | Update request valid |
| upd_ready | output | 1 | Update accepted when valid |
| upd_op | input | 2 | 0 insert, 1 delete, 2 leaf write, 3 none |
| upd_len | input | LEN_W | Prefix length of an insert or delete |
| upd_key | input | ADDR_W | Prefix in the top bits, or leaf index in the low bits |
| upd_data | input | NH_W+1 | Next hop, or signed pivot entry |
| res_valid | output | 1 | Result pulse |
| res_nh | output | NH_W | Resolved next hop |
| res_len | output | LEN_W | Matched prefix length |
| res_miss | output | 1 | No prefix matched, default next hop returned |

## Verification
The bound checker watches the handshake and result rules on every cycle. These rules are: readiness falls only after an accepted lookup, the result is a single pulse produced while idle, updates are gated by idle and by the absence of a lookup offer, a miss always carries the default next hop at length 0, and a full-length match is never a miss. Only the bench scenarios can show that the resolved next hop and length are right. They also show that the longest set length wins, that deletes expose shorter routes, that negative pivot entries steer into the right chunk slot, that ignored updates leave lookups unchanged, and that latency follows the probe count for each length.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PIVOT = 3'd1,
        ST_SCAN  = 3'd2,
        ST_NHRD  = 3'd3,
        ST_LEAF  = 3'd4
    } lpm_state_e;

    typedef enum logic [1:0] {
        OP_INSERT  = 2'd0,
        OP_DELETE  = 2'd1,
        OP_LEAF_WR = 2'd2,
        OP_NONE    = 2'd3
    } lpm_op_e;

endpackage

// File: rtl/lpm_bitmap_bank.sv
// One presence bitmap per prefix length 0..PIVOT_LEN.
// The key is the top PIVOT_LEN address bits; length g uses its top g bits.
module lpm_bitmap_bank #(
    parameter int PIVOT_LEN = 8,
    parameter int LEN_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [LEN_W-1:0]     wr_len,
    input  logic [PIVOT_LEN-1:0] wr_key,
    input  logic                 wr_bit,
    input  logic [LEN_W-1:0]     rd_len,
    input  logic [PIVOT_LEN-1:0] rd_key,
    output logic                 rd_bit
);

    logic [PIVOT_LEN:0] lvl_bit;

    for (genvar g = 0; g <= PIVOT_LEN; g++) begin : g_lvl
        if (g == 0) begin : g_root
            logic bm_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bm_q <= 1'b0;
                end else if (wr_en && wr_len == LEN_W'(g)) begin
                    bm_q <= wr_bit;
                end
            end
            assign lvl_bit[g] = bm_q;
        end else begin : g_row
            logic [(1<<g)-1:0] bm_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bm_q <= '0;
                end else if (wr_en && wr_len == LEN_W'(g)) begin
                    bm_q[wr_key[PIVOT_LEN-1 -: g]] <= wr_bit;
                end
            end
            assign lvl_bit[g] = bm_q[rd_key[PIVOT_LEN-1 -: g]];
        end
    end

    always_comb begin
        rd_bit = 1'b0;
        for (int l = 0; l <= PIVOT_LEN; l++) begin
            if (rd_len == LEN_W'(l)) begin
                rd_bit = lvl_bit[l];
            end
        end
    end

endmodule

// File: rtl/lpm_short_nh_bank.sv
// Next-hop arrays for prefix lengths 0..PIVOT_LEN-1, one per length.
module lpm_short_nh_bank #(
    parameter int PIVOT_LEN = 8,
    parameter int LEN_W     = 4,
    parameter int NH_W      = 8,
    localparam int KEY_W    = PIVOT_LEN - 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [LEN_W-1:0] wr_len,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [NH_W-1:0]  wr_nh,
    input  logic [LEN_W-1:0] rd_len,
    input  logic [KEY_W-1:0] rd_key,
    output logic [NH_W-1:0]  rd_nh
);

    logic [NH_W-1:0] lvl_nh [PIVOT_LEN];

    for (genvar g = 0; g < PIVOT_LEN; g++) begin : g_lvl
        if (g == 0) begin : g_root
            logic [NH_W-1:0] nh_q;
            always_ff @(posedge clk) begin
                if (wr_en && wr_len == LEN_W'(g)) begin
                    nh_q <= wr_nh;
                end
            end
            assign lvl_nh[g] = nh_q;
        end else begin : g_row
            logic [NH_W-1:0] nh_q [1<<g];
            always_ff @(posedge clk) begin
                if (wr_en && wr_len == LEN_W'(g)) begin
                    nh_q[wr_key[KEY_W-1 -: g]] <= wr_nh;
                end
            end
            assign lvl_nh[g] = nh_q[rd_key[KEY_W-1 -: g]];
        end
    end

    always_comb begin
        rd_nh = '0;
        for (int l = 0; l < PIVOT_LEN; l++) begin
            if (rd_len == LEN_W'(l)) begin
                rd_nh = lvl_nh[l];
            end
        end
    end

endmodule

// File: rtl/lpm_ram.sv
// Flop array with one write port and one asynchronous read port.
module lpm_ram #(
    parameter int DEPTH = 256,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/lpm_engine.sv
module lpm_engine
    import lpm_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int          PIVOT_LEN  = 8,
    parameter int          NH_W       = 8,
    parameter int          NUM_CHUNKS = 8,
    parameter int unsigned DEFAULT_NH = 254,
    localparam int         LEN_W      = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    output logic              lk_ready,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              upd_valid,
    output logic              upd_ready,
    input  logic [1:0]        upd_op,
    input  logic [LEN_W-1:0]  upd_len,
    input  logic [ADDR_W-1:0] upd_key,
    input  logic [NH_W:0]     upd_data,
    output logic              res_valid,
    output logic [NH_W-1:0]   res_nh,
    output logic [LEN_W-1:0]  res_len,
    output logic              res_miss
);

    localparam int LOW_W      = ADDR_W - PIVOT_LEN;
    localparam int CHUNK_AW   = $clog2(NUM_CHUNKS);
    localparam int LEAF_AW    = CHUNK_AW + LOW_W;
    localparam int LEAF_DEPTH = 1 << LEAF_AW;
    localparam int PIV_DEPTH  = 1 << PIVOT_LEN;
    localparam int ENT_W      = NH_W + 1;

    typedef struct packed {
        lpm_state_e          state;
        logic [ADDR_W-1:0]   addr;
        logic [LEN_W-1:0]    level;
        logic [LEAF_AW-1:0]  leaf_idx;
        logic                res_valid;
        logic                res_miss;
        logic [NH_W-1:0]     res_nh;
        logic [LEN_W-1:0]    res_len;
    } eng_st_t;

    eng_st_t st_d, st_q;

    logic               upd_fire;
    logic               len_ok;
    logic               bm_wr_en;
    logic               bm_bit;
    logic               snh_wr_en;
    logic [NH_W-1:0]    snh_rd;
    logic               piv_wr_en;
    logic [ENT_W-1:0]   piv_entry;
    logic               leaf_wr_en;
    logic [NH_W-1:0]    leaf_rd;
    logic [CHUNK_AW-1:0] chunk_sel;

    // ------------------------------------------------------------
    // Update decode: one write into one store per accepted update
    // ------------------------------------------------------------
    assign lk_ready   = (st_q.state == ST_IDLE);
    assign upd_ready  = lk_ready && !lk_valid;
    assign upd_fire   = upd_valid && upd_ready;
    assign len_ok     = (upd_len <= LEN_W'(PIVOT_LEN));
    assign bm_wr_en   = upd_fire && len_ok
                        && (upd_op == OP_INSERT || upd_op == OP_DELETE);
    assign snh_wr_en  = upd_fire && (upd_op == OP_INSERT)
                        && (upd_len < LEN_W'(PIVOT_LEN));
    assign piv_wr_en  = upd_fire && (upd_op == OP_INSERT)
                        && (upd_len == LEN_W'(PIVOT_LEN));
    assign leaf_wr_en = upd_fire && (upd_op == OP_LEAF_WR);

    // ------------------------------------------------------------
    // Stores
    // ------------------------------------------------------------
    lpm_bitmap_bank #(
        .PIVOT_LEN (PIVOT_LEN),
        .LEN_W     (LEN_W)
    ) bitmap_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bm_wr_en),
        .wr_len (upd_len),
        .wr_key (upd_key[ADDR_W-1 -: PIVOT_LEN]),
        .wr_bit (upd_op == OP_INSERT),
        .rd_len (st_q.level),
        .rd_key (st_q.addr[ADDR_W-1 -: PIVOT_LEN]),
        .rd_bit (bm_bit)
    );

    lpm_short_nh_bank #(
        .PIVOT_LEN (PIVOT_LEN),
        .LEN_W     (LEN_W),
        .NH_W      (NH_W)
    ) short_nh_i (
        .clk    (clk),
        .wr_en  (snh_wr_en),
        .wr_len (upd_len),
        .wr_key (upd_key[ADDR_W-1 -: PIVOT_LEN-1]),
        .wr_nh  (upd_data[NH_W-1:0]),
        .rd_len (st_q.level),
        .rd_key (st_q.addr[ADDR_W-1 -: PIVOT_LEN-1]),
        .rd_nh  (snh_rd)
    );

    lpm_ram #(
        .DEPTH (PIV_DEPTH),
        .W     (ENT_W)
    ) pivot_i (
        .clk     (clk),
        .wr_en   (piv_wr_en),
        .wr_idx  (upd_key[ADDR_W-1 -: PIVOT_LEN]),
        .wr_data (upd_data),
        .rd_idx  (st_q.addr[ADDR_W-1 -: PIVOT_LEN]),
        .rd_data (piv_entry)
    );

    lpm_ram #(
        .DEPTH (LEAF_DEPTH),
        .W     (NH_W)
    ) leaf_i (
        .clk     (clk),
        .wr_en   (leaf_wr_en),
        .wr_idx  (upd_key[LEAF_AW-1:0]),
        .wr_data (upd_data[NH_W-1:0]),
        .rd_idx  (st_q.leaf_idx),
        .rd_data (leaf_rd)
    );

    // A negative entry -c gives c-1 as its bitwise inverse.
    assign chunk_sel = ~piv_entry[CHUNK_AW-1:0];

    // ------------------------------------------------------------
    // Next-state logic
    // ------------------------------------------------------------
    always_comb begin
        st_d           = st_q;
        st_d.res_valid = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (lk_valid) begin
                    st_d.addr  = lk_addr;
                    st_d.level = LEN_W'(PIVOT_LEN);
                    st_d.state = ST_PIVOT;
                end
            end
            ST_PIVOT: begin
                if (bm_bit) begin
                    if (!piv_entry[NH_W]) begin
                        st_d.res_valid = 1'b1;
                        st_d.res_miss  = 1'b0;
                        st_d.res_nh    = piv_entry[NH_W-1:0];
                        st_d.res_len   = LEN_W'(PIVOT_LEN);
                        st_d.state     = ST_IDLE;
                    end else begin
                        st_d.leaf_idx  = {chunk_sel, st_q.addr[LOW_W-1:0]};
                        st_d.state     = ST_LEAF;
                    end
                end else begin
                    st_d.level = LEN_W'(PIVOT_LEN - 1);
                    st_d.state = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (bm_bit) begin
                    st_d.state = ST_NHRD;
                end else if (st_q.level == '0) begin
                    st_d.res_valid = 1'b1;
                    st_d.res_miss  = 1'b1;
                    st_d.res_nh    = NH_W'(DEFAULT_NH);
                    st_d.res_len   = '0;
                    st_d.state     = ST_IDLE;
                end else begin
                    st_d.level = st_q.level - LEN_W'(1);
                end
            end
            ST_NHRD: begin
                st_d.res_valid = 1'b1;
                st_d.res_miss  = 1'b0;
                st_d.res_nh    = snh_rd;
                st_d.res_len   = st_q.level;
                st_d.state     = ST_IDLE;
            end
            ST_LEAF: begin
                st_d.res_valid = 1'b1;
                st_d.res_miss  = 1'b0;
                st_d.res_nh    = leaf_rd;
                st_d.res_len   = LEN_W'(ADDR_W);
                st_d.state     = ST_IDLE;
            end
            default: begin
                st_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.res_valid;
    assign res_nh    = st_q.res_nh;
    assign res_len   = st_q.res_len;
    assign res_miss  = st_q.res_miss;

endmodule

// File: rtl/lpm_engine_chk.sv
module lpm_engine_chk #(
    parameter int          ADDR_W     = 12,
    parameter int          NH_W       = 8,
    parameter int unsigned DEFAULT_NH = 254,
    localparam int         LEN_W      = $clog2(ADDR_W + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             lk_ready,
    input logic             upd_ready,
    input logic             res_valid,
    input logic [NH_W-1:0]  res_nh,
    input logic [LEN_W-1:0] res_len,
    input logic             res_miss
);

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && lk_ready |=> !lk_ready);

    // R9
    ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lk_ready) |-> $past(lk_valid));

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R9
    result_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> lk_ready);

    // R10
    upd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_ready |-> (lk_ready && !lk_valid));

    // R5
    miss_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_miss |-> (res_nh == NH_W'(DEFAULT_NH)) && (res_len == '0));

    // R3
    long_match_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && (res_len == LEN_W'(ADDR_W)) |-> !res_miss);

endmodule

bind lpm_engine lpm_engine_chk #(
    .ADDR_W     (ADDR_W),
    .NH_W       (NH_W),
    .DEFAULT_NH (DEFAULT_NH)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_ready  (lk_ready),
    .upd_ready (upd_ready),
    .res_valid (res_valid),
    .res_nh    (res_nh),
    .res_len   (res_len),
    .res_miss  (res_miss)
);

// File: tb/lpm_engine_tb.sv
module lpm_engine_tb_top;

    localparam int AW   = 12;
    localparam int PL   = 8;
    localparam int NW   = 8;
    localparam int NCH  = 8;
    localparam int DNH  = 254;
    localparam int LW   = $clog2(AW + 1);
    localparam int LOWW = AW - PL;
    localparam int LEAFN = NCH << LOWW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic          lk_ready;
    logic [AW-1:0] lk_addr = '0;
    logic          upd_valid = 1'b0;
    logic          upd_ready;
    logic [1:0]    upd_op = '0;
    logic [LW-1:0] upd_len = '0;
    logic [AW-1:0] upd_key = '0;
    logic [NW:0]   upd_data = '0;
    logic          res_valid;
    logic [NW-1:0] res_nh;
    logic [LW-1:0] res_len;
    logic          res_miss;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    lpm_engine #(
        .ADDR_W (AW), .PIVOT_LEN (PL), .NH_W (NW),
        .NUM_CHUNKS (NCH), .DEFAULT_NH (DNH)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .lk_valid (lk_valid), .lk_ready (lk_ready), .lk_addr (lk_addr),
        .upd_valid (upd_valid), .upd_ready (upd_ready), .upd_op (upd_op),
        .upd_len (upd_len), .upd_key (upd_key), .upd_data (upd_data),
        .res_valid (res_valid), .res_nh (res_nh), .res_len (res_len),
        .res_miss (res_miss)
    );

    // Reference table
    bit            m_bm   [0:PL][0:(1<<PL)-1];
    logic [NW-1:0] m_nh   [0:PL-1][0:(1<<PL)-1];
    logic [NW:0]   m_piv  [0:(1<<PL)-1];
    logic [NW-1:0] m_leaf [0:LEAFN-1];
    logic [AW-1:0] recent [0:15];

    task automatic check(input bit ok, input string req, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    function automatic int pidx(input logic [AW-1:0] k, input int len);
        return int'(k >> (AW - len));
    endfunction

    task automatic ref_lookup(input logic [AW-1:0] a, output logic [NW-1:0] nh,
                              output int len, output bit miss, output int lat);
        int pi;
        pi   = pidx(a, PL);
        miss = 1'b0;
        if (m_bm[PL][pi]) begin
            if (!m_piv[pi][NW]) begin
                nh = m_piv[pi][NW-1:0]; len = PL; lat = 1;
            end else begin
                int c;
                c   = -int'($signed(m_piv[pi]));
                nh  = m_leaf[((c - 1) % NCH) * (1 << LOWW) + int'(a[LOWW-1:0])];
                len = AW; lat = 2;
            end
            return;
        end
        for (int l = PL - 1; l >= 0; l--) begin
            if (m_bm[l][pidx(a, l)]) begin
                nh = m_nh[l][pidx(a, l)]; len = l; lat = PL - l + 2;
                return;
            end
        end
        nh = NW'(DNH); len = 0; miss = 1'b1; lat = PL + 1;
    endtask

    task automatic do_update(input logic [1:0] op, input int len,
                             input logic [AW-1:0] key, input logic [NW:0] data);
        @(negedge clk);
        upd_op = op; upd_len = LW'(len); upd_key = key; upd_data = data;
        upd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        upd_valid = 1'b0;
        if (op == 2'd0 && len <= PL) begin
            m_bm[len][pidx(key, len)] = 1'b1;
            if (len < PL) m_nh[len][pidx(key, len)] = data[NW-1:0];
            else          m_piv[pidx(key, len)] = data;
        end else if (op == 2'd1 && len <= PL) begin
            m_bm[len][pidx(key, len)] = 1'b0;
        end else if (op == 2'd2) begin
            m_leaf[int'(key) % LEAFN] = data[NW-1:0];
        end
    endtask

    task automatic do_lookup(input logic [AW-1:0] a, input bit hs);
        logic [NW-1:0] e_nh;
        int e_len, e_lat, lat;
        bit e_miss, got;
        string tag;
        ref_lookup(a, e_nh, e_len, e_miss, e_lat);
        tag = e_miss ? "R5" : (e_lat == 1) ? "R2" : (e_lat == 2) ? "R3" : "R4";
        @(negedge clk);
        lk_addr = a; lk_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0;
        if (hs) check(lk_ready == 1'b0, "R9",
                      $sformatf("lk_ready busy act=%0b exp=0", lk_ready));
        lat = 0; got = 1'b0;
        while (!got && lat < 100) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
            if (res_valid) got = 1'b1;
        end
        check(got && res_nh == e_nh && int'(res_len) == e_len && res_miss == e_miss
              && lat == e_lat, tag,
              $sformatf("addr=%h act nh=%h len=%0d miss=%0b lat=%0d exp nh=%h len=%0d miss=%0b lat=%0d",
                        a, res_nh, res_len, res_miss, lat, e_nh, e_len, e_miss, e_lat));
        if (hs) begin
            @(negedge clk);
            check(res_valid == 1'b0 && lk_ready == 1'b1, "R9",
                  $sformatf("after result valid=%0b ready=%0b exp 0/1", res_valid, lk_ready));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int l = 0; l <= PL; l++)
            for (int i = 0; i < (1 << PL); i++) m_bm[l][i] = 1'b0;
        for (int i = 0; i < 16; i++) recent[i] = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(lk_ready == 1'b1 && upd_ready == 1'b1 && res_valid == 1'b0, "R1",
              $sformatf("ready=%0b upd_ready=%0b valid=%0b exp 1/1/0",
                        lk_ready, upd_ready, res_valid));
        // R1 / R5: empty table misses
        do_lookup(12'h5A3, 1'b1);

        // R8: fill the whole leaf table
        for (int i = 0; i < LEAFN; i++)
            do_update(2'd2, 0, AW'(i), {1'b0, NW'($urandom)});

        // R2 / R6: pivot-length route
        do_update(2'd0, PL, 12'hAB0, 9'h015);
        do_lookup(12'hAB7, 1'b1);
        // R4: length 4 route, then a longer length 6 route over it
        do_update(2'd0, 4, 12'hA00, 9'h044);
        do_lookup(12'hA5F, 1'b1);
        do_update(2'd0, 6, 12'hA40, 9'h066);
        do_lookup(12'hA5F, 1'b0);
        // R4: default route at length 0
        do_update(2'd0, 0, 12'h000, 9'h077);
        do_lookup(12'h123, 1'b0);
        // R7: delete exposes shorter routes
        do_update(2'd1, 0, 12'h000, 9'h000);
        do_lookup(12'h123, 1'b0);
        do_update(2'd1, 6, 12'hA40, 9'h000);
        do_lookup(12'hA5F, 1'b0);
        // R3 / R8: chunk 3 pointer, slot 5
        do_update(2'd2, 0, AW'(2 * 16 + 5), 9'h099);
        do_update(2'd0, PL, 12'h3C0, 9'h1FD);
        do_lookup(12'h3C5, 1'b1);
        check(m_leaf[37] == 8'h99, "R3", "leaf model slot 37 act/exp mismatch");
        // R10: ignored updates leave lookups unchanged
        do_update(2'd0, PL + 1, 12'hFFF, 9'h033);
        do_update(2'd3, 4, 12'hF00, 9'h033);
        do_lookup(12'hFFF, 1'b0);

        // R10: update held off while a lookup is offered
        @(negedge clk);
        lk_addr = 12'hFFF; lk_valid = 1'b1;
        upd_op = 2'd0; upd_len = LW'(4); upd_key = 12'hF00; upd_data = 9'h011;
        upd_valid = 1'b1;
        #1;
        check(upd_ready == 1'b0 && lk_ready == 1'b1, "R10",
              $sformatf("upd_ready=%0b lk_ready=%0b exp 0/1", upd_ready, lk_ready));
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0;
        check(upd_ready == 1'b0, "R10", $sformatf("busy upd_ready=%0b exp 0", upd_ready));
        upd_valid = 1'b0;
        while (!res_valid) begin
            @(posedge clk);
            @(negedge clk);
        end
        do_lookup(12'hF12, 1'b0);

        // Random mix
        for (int it = 0; it < 600; it++) begin
            int sel;
            sel = int'($urandom % 100);
            if (sel < 35) begin
                int len;
                logic [AW-1:0] k;
                logic [NW:0] d;
                len = int'($urandom % (PL + 1));
                k   = AW'($urandom);
                if (len == PL && ($urandom % 10) < 3)
                    d = (NW + 1)'(-(1 + int'($urandom % NCH)));
                else
                    d = {1'b0, NW'($urandom)};
                do_update(2'd0, len, k, d);
                recent[it % 16] = k;
            end else if (sel < 45) begin
                do_update(2'd1, int'($urandom % (PL + 1)), recent[$urandom % 16], '0);
            end else if (sel < 50) begin
                do_update(2'd2, 0, AW'($urandom), {1'b0, NW'($urandom)});
            end else if (sel < 75) begin
                do_lookup({recent[$urandom % 16][AW-1:LOWW], LOWW'($urandom)}, 1'b0);
            end else begin
                do_lookup(AW'($urandom), 1'b0);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule